// File: doc/BRIEF.md
# Global Counter With Per-Core Compare Timers

This block keeps one free-running 64-bit cycle counter shared by every core of a cluster and gives each core its own 64-bit compare value. A core whose compare value equals the counter gets a sticky compare-pending flag. If that core's timer is routable and its timer map register enables routing, the flag also drives one of that core's interrupt pins. Software sees every 64-bit quantity as two independent 32-bit halves on a single register port. The requester's core index travels with each access.

The register space has three windows. The shared window holds the counter halves. The local window holds the requesting core's own registers. The remote window holds the registers of whichever core the requester has named in its own remote-select register. This lets one core arm or inspect another core's timer without an extra port. Reads return data one cycle after the request.

Top module: `glb_timer`

## Requirements
- R1: After synchronous reset the counter is 0 and every pending flag, map enable, pin field, remote select and interrupt output is 0. Every compare register is all ones.
- R2: The counter advances by exactly one on every clock cycle out of reset and is visible on `count_o`.
- R3: Reads use `bus_addr[4:3]` as the window (0 shared, 1 local, 2 remote, 3 unmapped) and `bus_addr[2:0]` as the offset. In the shared window, offset 0 returns count bits 31:0 and offset 1 returns bits 63:32. The data appears on `bus_rdata` in the cycle after `bus_re` and is 0 in any cycle not following a read. Each half reflects the counter in its own read cycle, so a low read does not hold the high half.
- R4: Per-core offsets 3 and 4 read and write compare bits 31:0 and 63:32 respectively. Each core's compare is independent.
- R5: A core's pending flag sets in the cycle after the counter equals that core's full 64-bit compare, and stays set. A match on the low half alone does not set it.
- R6: A write to either compare half of a core clears its pending flag. The clear wins over a match in the same cycle.
- R7: Per-core offset 1 reads the pending flag in bit 0, and `cmp_pend_o` shows every core's flag.
- R8: Per-core offset 5 holds a core-index remote select. Accesses from core c to window 2 reach the registers of the core named by c's select.
- R9: Per-core offset 0 is read-only. Bit 0 is the timer-routable flag and bit 1 is the perf-counter-routable flag, both taken from parameters. Writes to it have no effect.
- R10: Per-core offset 2 holds a map enable in bit 31 and a pin number in the low bits. `timer_irq[c*NPINS+p]` is high exactly when core c is pending, its map is enabled, its timer is routable and its pin field equals p. A pin number at or above NPINS drives nothing.
- R11: Writes to the shared window and to unmapped offsets change nothing. Reads there, or in window 3, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_core | input | CORE_W | Index of the requesting core |
| bus_addr | input | 5 | Window in bits 4:3, offset in bits 2:0 |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_re` |
| count_o | output | 64 | Current counter value |
| cmp_pend_o | output | NCORES | Per-core compare-pending flags |
| timer_irq | output | NCORES*NPINS | Per-core timer interrupt pins |

## Verification
The bench reads the counter's low half and then its high half in separate cycles and expects values from two different cycles. A design that latched the high half on the low read would return a stale value. It arms a compare whose low half matches while the high half differs, which catches a design that compares only 32 bits. It rewrites a compare half in the very cycle the compare matches, so a design that lets the set win over the clear leaves the flag high. It also arms another core's timer through the remote window and maps pins that are out of range or belong to a non-routable core. A wrong target decode or a missing routable gate then shows up as a flag or pin on the wrong core.

// File: rtl/glb_timer_pkg.sv
package glb_timer_pkg;

    typedef enum logic [1:0] {
        WIN_SHARED = 2'd0,
        WIN_LOCAL  = 2'd1,
        WIN_REMOTE = 2'd2,
        WIN_NONE   = 2'd3
    } win_e;

    localparam logic [2:0] OFF_CNT_LO = 3'd0;
    localparam logic [2:0] OFF_CNT_HI = 3'd1;

    localparam logic [2:0] OFF_CTRL   = 3'd0;
    localparam logic [2:0] OFF_PEND   = 3'd1;
    localparam logic [2:0] OFF_TMAP   = 3'd2;
    localparam logic [2:0] OFF_CMP_LO = 3'd3;
    localparam logic [2:0] OFF_CMP_HI = 3'd4;
    localparam logic [2:0] OFF_RSEL   = 3'd5;

    typedef struct packed {
        logic        we;
        logic [2:0]  off;
        logic [31:0] wdata;
    } core_req_t;

    function automatic logic [31:0] half32(input logic [63:0] v, input logic upper);
        return upper ? v[63:32] : v[31:0];
    endfunction

endpackage

// File: rtl/glb_timer_cnt.sv
module glb_timer_cnt #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_q + CNT_W'(1);
    end

    assign count = count_q;
endmodule

// File: rtl/glb_timer_core.sv
module glb_timer_core
    import glb_timer_pkg::*;
#(
    parameter int NPINS   = 6,
    parameter int CORE_W  = 2,
    parameter bit TMR_RT  = 1'b1,
    parameter bit PERF_RT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [63:0]       count,
    input  core_req_t         req,
    output logic [31:0]       rdata,
    output logic [CORE_W-1:0] rsel,
    output logic              pend,
    output logic [63:0]       cmp,
    output logic [NPINS-1:0]  irq
);
    localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1;

    logic [63:0]       cmp_q;
    logic              pend_q;
    logic              map_en_q;
    logic [PIN_W-1:0]  map_pin_q;
    logic [CORE_W-1:0] rsel_q;
    logic              hit;

    assign hit = (count == cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q     <= '1;
            pend_q    <= 1'b0;
            map_en_q  <= 1'b0;
            map_pin_q <= '0;
            rsel_q    <= '0;
        end else begin
            if (hit) pend_q <= 1'b1;
            if (req.we) begin
                case (req.off)
                    OFF_TMAP: begin
                        map_en_q  <= req.wdata[31];
                        map_pin_q <= req.wdata[PIN_W-1:0];
                    end
                    OFF_CMP_LO: begin
                        cmp_q[31:0] <= req.wdata;
                        pend_q      <= 1'b0;
                    end
                    OFF_CMP_HI: begin
                        cmp_q[63:32] <= req.wdata;
                        pend_q       <= 1'b0;
                    end
                    OFF_RSEL: rsel_q <= req.wdata[CORE_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        assign irq[p] = pend_q & map_en_q & TMR_RT & (map_pin_q == PIN_W'(p));
    end

    always_comb begin
        case (req.off)
            OFF_CTRL:   rdata = {30'd0, PERF_RT, TMR_RT};
            OFF_PEND:   rdata = {31'd0, pend_q};
            OFF_TMAP:   rdata = {map_en_q, {(31-PIN_W){1'b0}}, map_pin_q};
            OFF_CMP_LO: rdata = half32(cmp_q, 1'b0);
            OFF_CMP_HI: rdata = half32(cmp_q, 1'b1);
            OFF_RSEL:   rdata = {{(32-CORE_W){1'b0}}, rsel_q};
            default:    rdata = 32'd0;
        endcase
    end

    logic unused_wdata;
    assign unused_wdata = ^req.wdata[30:PIN_W] ^ ^req.wdata[31:CORE_W];

    assign rsel = rsel_q;
    assign pend = pend_q;
    assign cmp  = cmp_q;
endmodule

// File: rtl/glb_timer.sv
module glb_timer
    import glb_timer_pkg::*;
#(
    parameter int              NCORES    = 4,
    parameter int              NPINS     = 6,
    parameter logic [NCORES-1:0] TMR_RTBL  = 4'b1011,
    parameter logic [NCORES-1:0] PERF_RTBL = 4'b0111,
    parameter int              CORE_W    = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [CORE_W-1:0]       bus_core,
    input  logic [4:0]              bus_addr,
    input  logic                    bus_we,
    input  logic                    bus_re,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic [63:0]             count_o,
    output logic [NCORES-1:0]       cmp_pend_o,
    output logic [NCORES*NPINS-1:0] timer_irq
);
    win_e              win;
    logic [2:0]        off;
    logic [CORE_W-1:0] tgt;
    logic              src_ok;
    logic              tgt_ok;
    logic              core_win;
    logic [63:0]       count;
    logic [31:0]       rd_val;
    logic [31:0]       rdata_q;

    logic [31:0]          core_rdata [NCORES];
    logic [CORE_W-1:0]    core_rsel  [NCORES];
    logic [NCORES*64-1:0] cmp_flat;

    glb_timer_cnt #(.CNT_W(64)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .count (count)
    );

    assign win      = win_e'(bus_addr[4:3]);
    assign off      = bus_addr[2:0];
    assign core_win = (win == WIN_LOCAL) || (win == WIN_REMOTE);
    assign src_ok   = int'(bus_core) < NCORES;

    always_comb begin
        tgt = bus_core;
        if (win == WIN_REMOTE && src_ok) tgt = core_rsel[bus_core];
    end

    assign tgt_ok = src_ok && (int'(tgt) < NCORES);

    for (genvar i = 0; i < NCORES; i++) begin : g_core
        core_req_t req;
        assign req.we    = bus_we && core_win && tgt_ok && (tgt == CORE_W'(i));
        assign req.off   = off;
        assign req.wdata = bus_wdata;

        glb_timer_core #(
            .NPINS   (NPINS),
            .CORE_W  (CORE_W),
            .TMR_RT  (TMR_RTBL[i]),
            .PERF_RT (PERF_RTBL[i])
        ) u_core (
            .clk   (clk),
            .rst   (rst),
            .count (count),
            .req   (req),
            .rdata (core_rdata[i]),
            .rsel  (core_rsel[i]),
            .pend  (cmp_pend_o[i]),
            .cmp   (cmp_flat[i*64 +: 64]),
            .irq   (timer_irq[i*NPINS +: NPINS])
        );
    end

    always_comb begin
        rd_val = 32'd0;
        if (win == WIN_SHARED) begin
            if (off == OFF_CNT_LO)      rd_val = half32(count, 1'b0);
            else if (off == OFF_CNT_HI) rd_val = half32(count, 1'b1);
        end else if (core_win && tgt_ok) begin
            rd_val = core_rdata[tgt];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata_q <= 32'd0;
        else     rdata_q <= bus_re ? rd_val : 32'd0;
    end

    assign bus_rdata = rdata_q;
    assign count_o   = count;
endmodule

// File: rtl/glb_timer_chk.sv
module glb_timer_chk #(
    parameter int              NCORES   = 4,
    parameter int              NPINS    = 6,
    parameter int              CORE_W   = 2,
    parameter logic [NCORES-1:0] TMR_RTBL = '1
) (
    input logic                    clk,
    input logic                    rst,
    input logic [CORE_W-1:0]       bus_core,
    input logic [4:0]              bus_addr,
    input logic                    bus_we,
    input logic [63:0]             count_o,
    input logic [NCORES-1:0]       cmp_pend_o,
    input logic [NCORES*NPINS-1:0] timer_irq,
    input logic [NCORES*64-1:0]    cmp_flat
);
    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> count_o == $past(count_o) + 64'd1);

    // R6
    cmp_wr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr[4:3] == 2'd1 && (bus_addr[2:0] == 3'd3 || bus_addr[2:0] == 3'd4))
        |=> !cmp_pend_o[$past(bus_core)]);

    for (genvar c = 0; c < NCORES; c++) begin : g_chk
        // R5
        pend_rise_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(cmp_pend_o[c]) |-> $past(count_o) == $past(cmp_flat[c*64 +: 64]));
        // R10
        irq_onehot_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot0(timer_irq[c*NPINS +: NPINS]));
        // R10
        irq_pend_chk: assert property (@(posedge clk) disable iff (rst)
            (|timer_irq[c*NPINS +: NPINS]) |-> cmp_pend_o[c]);
        // R10
        irq_rtbl_chk: assert property (@(posedge clk) disable iff (rst)
            !TMR_RTBL[c] |-> timer_irq[c*NPINS +: NPINS] == '0);
    end
endmodule

bind glb_timer glb_timer_chk #(
    .NCORES   (NCORES),
    .NPINS    (NPINS),
    .CORE_W   (CORE_W),
    .TMR_RTBL (TMR_RTBL)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_core   (bus_core),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .count_o    (count_o),
    .cmp_pend_o (cmp_pend_o),
    .timer_irq  (timer_irq),
    .cmp_flat   (cmp_flat)
);

// File: tb/glb_timer_bench.sv
`timescale 1ns/1ps
module glb_timer_bench;
    localparam int       NC    = 4;
    localparam int       NP    = 6;
    localparam bit [3:0] TMR   = 4'b1011;
    localparam bit [3:0] PERF  = 4'b0111;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_core = '0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] count_o;
    logic [NC-1:0]    cmp_pend_o;
    logic [NC*NP-1:0] timer_irq;

    always #2.5 clk = ~clk;

    glb_timer #(.NCORES(NC), .NPINS(NP), .TMR_RTBL(TMR), .PERF_RTBL(PERF)) u_glb_timer (
        .clk(clk), .rst(rst), .bus_core(bus_core), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .count_o(count_o), .cmp_pend_o(cmp_pend_o),
        .timer_irq(timer_irq)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string cur_tag = "R1";

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    logic [63:0] m_cnt;
    logic [63:0] m_cmp  [NC];
    bit          m_pend [NC];
    bit          m_en   [NC];
    logic [2:0]  m_pin  [NC];
    logic [1:0]  m_rsel [NC];
    logic [31:0] m_rd;

    always @(posedge clk) begin
        int          t;
        logic [1:0]  w;
        logic [2:0]  o;
        logic [31:0] rv;
        bit          hit [NC];
        if (rst) begin
            m_cnt = 0; m_rd = 0;
            for (int c = 0; c < NC; c++) begin
                m_cmp[c] = '1; m_pend[c] = 0; m_en[c] = 0; m_pin[c] = 0; m_rsel[c] = 0;
            end
        end else begin
            w = bus_addr[4:3];
            o = bus_addr[2:0];
            t = (w == 2'd2) ? int'(m_rsel[bus_core]) : int'(bus_core);
            rv = 0;
            if (w == 2'd0) begin
                if (o == 0) rv = m_cnt[31:0];
                if (o == 1) rv = m_cnt[63:32];
            end else if (w != 2'd3) begin
                case (o)
                    0: rv = {30'd0, PERF[t], TMR[t]};
                    1: rv = {31'd0, m_pend[t]};
                    2: rv = {m_en[t], 28'd0, m_pin[t]};
                    3: rv = m_cmp[t][31:0];
                    4: rv = m_cmp[t][63:32];
                    5: rv = {30'd0, m_rsel[t]};
                    default: rv = 0;
                endcase
            end
            m_rd = bus_re ? rv : 32'd0;
            for (int c = 0; c < NC; c++) hit[c] = (m_cnt == m_cmp[c]);
            for (int c = 0; c < NC; c++) if (hit[c]) m_pend[c] = 1;
            if (bus_we && (w == 2'd1 || w == 2'd2)) begin
                case (o)
                    2: begin m_en[t] = bus_wdata[31]; m_pin[t] = bus_wdata[2:0]; end
                    3: begin m_cmp[t][31:0]  = bus_wdata; m_pend[t] = 0; end
                    4: begin m_cmp[t][63:32] = bus_wdata; m_pend[t] = 0; end
                    5: m_rsel[t] = bus_wdata[1:0];
                    default: ;
                endcase
            end
            m_cnt = m_cnt + 1;
        end
    end

    // compare against the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2", count_o, m_cnt);
            for (int c = 0; c < NC; c++) begin
                chk("R5", {63'd0, cmp_pend_o[c]}, {63'd0, m_pend[c]});
                for (int p = 0; p < NP; p++)
                    chk("R10", {63'd0, timer_irq[c*NP+p]},
                        {63'd0, m_pend[c] & m_en[c] & TMR[c] & (m_pin[c] == 3'(p))});
            end
            chk(cur_tag, {32'd0, bus_rdata}, {32'd0, m_rd});
        end
    end

    task automatic acc(input logic [1:0] core, input logic [4:0] addr,
                       input bit we, input logic [31:0] d);
        bus_core = core; bus_addr = addr; bus_we = we; bus_re = !we; bus_wdata = d;
        @(negedge clk);
        bus_we = 0; bus_re = 0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] lo;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", count_o, 64'd0);
        chk("R1", {60'd0, cmp_pend_o}, 64'd0);
        chk("R1", {40'd0, timer_irq}, 64'd0);
        rst = 0;
        cur_tag = "R1";
        acc(0, 5'b01_011, 0, 0);
        acc(1, 5'b01_100, 0, 0);
        acc(2, 5'b01_010, 0, 0);
        acc(3, 5'b01_101, 0, 0);
        // R3 counter halves, read in separate cycles
        cur_tag = "R3";
        acc(0, 5'b00_000, 0, 0);
        acc(0, 5'b00_001, 0, 0);
        acc(2, 5'b00_000, 0, 0);
        // R9 control flags read-only
        cur_tag = "R9";
        for (int c = 0; c < NC; c++) acc(2'(c), 5'b01_000, 0, 0);
        acc(2, 5'b01_000, 1, 32'hFFFF_FFFF);
        acc(2, 5'b01_000, 0, 0);
        // R10 maps: routed, out-of-range pin, non-routable, disabled
        cur_tag = "R10";
        acc(0, 5'b01_010, 1, 32'h8000_0002);
        acc(1, 5'b01_010, 1, 32'h8000_0007);
        acc(2, 5'b01_010, 1, 32'h8000_0001);
        acc(3, 5'b01_010, 1, 32'h0000_0004);
        acc(0, 5'b01_010, 0, 0);
        // R4 arm compares
        cur_tag = "R4";
        for (int c = 0; c < NC; c++) begin
            acc(2'(c), 5'b01_100, 1, 32'd0);
            acc(2'(c), 5'b01_011, 1, m_cnt[31:0] + 32'd40 + 32'(8*c));
        end
        for (int c = 0; c < NC; c++) acc(2'(c), 5'b01_011, 0, 0);
        idle(80);
        // R7 pending readback
        cur_tag = "R7";
        for (int c = 0; c < NC; c++) acc(2'(c), 5'b01_001, 0, 0);
        chk("R7", {60'd0, cmp_pend_o}, 64'hF);
        // R6 clear by compare write
        cur_tag = "R6";
        acc(0, 5'b01_100, 1, 32'd0);
        chk("R6", {63'd0, cmp_pend_o[0]}, 64'd0);
        // R8 remote window
        cur_tag = "R8";
        acc(1, 5'b01_101, 1, 32'd3);
        acc(1, 5'b10_011, 0, 0);
        acc(1, 5'b10_001, 0, 0);
        acc(1, 5'b10_011, 1, m_cnt[31:0] + 32'd20);
        chk("R8", {60'd0, cmp_pend_o}, 64'b0110);
        acc(1, 5'b10_011, 0, 0);
        idle(30);
        chk("R8", {63'd0, cmp_pend_o[3]}, 64'd1);
        // R5 low half matches, high half does not
        cur_tag = "R5";
        acc(2, 5'b01_100, 1, 32'd1);
        acc(2, 5'b01_011, 1, m_cnt[31:0] + 32'd5);
        idle(20);
        chk("R5", {63'd0, cmp_pend_o[2]}, 64'd0);
        // R6 write lands in the matching cycle
        cur_tag = "R6";
        acc(0, 5'b01_100, 1, m_cnt[63:32]);
        lo = m_cnt[31:0] + 32'd1;
        acc(0, 5'b01_011, 1, lo);
        acc(0, 5'b01_100, 1, m_cnt[63:32]);
        idle(3);
        chk("R6", {63'd0, cmp_pend_o[0]}, 64'd0);
        // R11 ignored writes and unmapped reads
        cur_tag = "R11";
        acc(0, 5'b00_000, 1, 32'd0);
        acc(0, 5'b00_001, 1, 32'hFFFF);
        acc(1, 5'b01_110, 1, 32'h1234);
        acc(1, 5'b01_110, 0, 0);
        acc(1, 5'b11_011, 0, 0);
        acc(1, 5'b00_101, 0, 0);
        idle(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule